// File: doc/BRIEF.md
# Script Jump and Table Address Generator

This block resolves the addresses that script I/O instructions need. On a start strobe it latches a jump target. For the four connection-oriented instruction kinds, a set relative-mode bit turns the target into the current script pointer plus a sign-extended 24-bit displacement. Every other case uses the 32-bit jump field as an absolute address. When the table-mode bit is set, it also forms a table address from the data-structure base register plus a sign-extended 24-bit offset taken from the byte-count field. A signed 24-bit offset reaches at most 8 MB above or below the base. The block then issues one memory read at that address and unpacks the returned word into four 8-bit per-device transfer settings.

The block is a four-state machine. The states are IDLE (waiting for start), READ (holding the memory request until read data is valid), DONE (one-cycle completion) and FAULT (one-cycle completion with an alignment error). The transitions are:
- IDLE→DONE on start without table mode.
- IDLE→READ on start in table mode with an aligned base.
- IDLE→FAULT on start in table mode with a misaligned base.
- READ→DONE on read-data-valid.
- DONE→IDLE and FAULT→IDLE unconditionally.

All additions wrap modulo 2^32.

Top module: `script_addr_gen`

## Requirements
- R1: When `rel_mode` is 1 and `op_kind` is 0, 1, 2 or 3, `jump_target` becomes `script_ptr + sign_extend(jump_field[23:0])` modulo 2^32, latched at start.
- R2: When `rel_mode` is 0, or `op_kind` is 4 to 7, `jump_target` becomes the full 32-bit `jump_field`, latched at start.
- R3: In table mode with `base_addr[1:0]` equal to 0, `mem_req` rises the cycle after start with `mem_addr = base_addr + sign_extend(count_field)` modulo 2^32. Both stay unchanged until the cycle `mem_rvalid` is sampled high.
- R4: In table mode with `base_addr[1:0]` nonzero, no read is issued, and `align_err` and `done` are both high for exactly the one cycle after start.
- R5: The accepted read word is unpacked with bits 31:24 into `xfer_timing`, 23:16 into `xfer_id`, 15:8 into `xfer_offset` and 7:0 into `xfer_period`.
- R6: The four settings change only in a cycle where `mem_rvalid` is high while a read is pending. `mem_rvalid` at any other time is ignored.
- R7: `done` is a single-cycle pulse. It comes one cycle after start when no read is made, and one cycle after the cycle in which `mem_rvalid` is accepted when a read is made.
- R8: A start strobe while `busy` is high is ignored. The pending address and the latched jump target are kept.
- R9: After reset, all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to resolve an instruction |
| op_kind | input | 3 | Instruction kind; 0..3 allow relative mode |
| rel_mode | input | 1 | Jump field is a signed displacement |
| tbl_mode | input | 1 | Fetch settings from the table |
| jump_field | input | 32 | Jump address or displacement (bits 23:0) |
| count_field | input | 24 | Signed table offset |
| script_ptr | input | 32 | Current script pointer |
| base_addr | input | 32 | Data-structure base register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Not idle |
| done | output | 1 | Completion pulse |
| align_err | output | 1 | Misaligned base reported with done |
| jump_target | output | 32 | Resolved jump target |
| xfer_timing | output | 8 | Timing control setting |
| xfer_id | output | 8 | Device ID setting |
| xfer_offset | output | 8 | Synchronous offset setting |
| xfer_period | output | 8 | Synchronous period setting |

## Verification
- When no read is made, `done`, `align_err` and `jump_target` are due in the cycle after the start edge, so the bench samples them at the next falling edge.
- When a read is made, `mem_req` and `mem_addr` are due in that same cycle and are rechecked at every falling edge of a wait of zero to two cycles.
- The settings and `done` are due in the cycle after the edge that sampled `mem_rvalid`, so the bench checks them one falling edge after it drives that strobe.
- One cycle after each completion, the bench confirms that `done` has dropped. It then drives a stray `mem_rvalid` while the block is idle and checks the settings again one falling edge later.

// File: rtl/sag_pkg.sv
package sag_pkg;
    localparam int ADDR_W   = 32;
    localparam int DISP_W   = 24;
    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 4;
    localparam int ALIGN_B  = 2;
    localparam int KIND_W   = 3;
    // op_kind values below this one may use relative addressing
    localparam int REL_KIND_LIMIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } sag_state_e;
endpackage

// File: rtl/sag_addr_calc.sv
module sag_addr_calc #(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 24,
    parameter int KIND_W  = 3,
    parameter int ALIGN_B = 2,
    parameter int REL_LIM = 4
) (
    input  logic [KIND_W-1:0] op_kind,
    input  logic              rel_mode,
    input  logic [ADDR_W-1:0] jump_field,
    input  logic [DISP_W-1:0] count_field,
    input  logic [ADDR_W-1:0] script_ptr,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] eff_target,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] offs_ext;
    logic              rel_ok;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{jump_field[DISP_W-1]}}, jump_field[DISP_W-1:0]};
            assign offs_ext = {{EXT_W{count_field[DISP_W-1]}}, count_field};
        end else begin : g_noext
            assign disp_ext = jump_field;
            assign offs_ext = count_field[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        rel_ok     = rel_mode && (int'(op_kind) < REL_LIM);
        eff_target = rel_ok ? (script_ptr + disp_ext) : jump_field;
        tbl_addr   = base_addr + offs_ext;
        misaligned = |base_addr[ALIGN_B-1:0];
    end
endmodule

// File: rtl/sag_unpack.sv
module sag_unpack #(
    parameter int FIELD_W  = 8,
    parameter int N_FIELDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [FIELD_W*N_FIELDS-1:0]   word,
    output logic [FIELD_W*N_FIELDS-1:0]   fields
);
    localparam int WORD_W = FIELD_W * N_FIELDS;

    generate
        for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fields[i*FIELD_W +: FIELD_W] <= '0;
                end else if (load) begin
                    fields[i*FIELD_W +: FIELD_W] <= word[i*FIELD_W +: FIELD_W];
                end
            end
        end
    endgenerate

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(fields)); // R6

    logic [WORD_W-1:0] unused_chk;
    assign unused_chk = fields;
endmodule

// File: rtl/sag_ctrl.sv
module sag_ctrl
    import sag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tbl_mode,
    input  logic [ADDR_W-1:0] eff_target,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              misaligned,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic              align_err,
    output logic [ADDR_W-1:0] jump_target,
    output logic              load_en
);
    sag_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!tbl_mode)       state_d = ST_DONE;
                    else if (misaligned) state_d = ST_FAULT;
                    else                 state_d = ST_READ;
                end
            end
            ST_READ:  if (mem_rvalid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jump_target <= '0;
            mem_addr    <= '0;
        end else if (accept) begin
            jump_target <= eff_target;
            mem_addr    <= tbl_addr;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        done      = 1'b0;
        align_err = 1'b0;
        load_en   = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ: begin
                mem_req = 1'b1;
                load_en = mem_rvalid;
            end
            ST_DONE:  done = 1'b1;
            ST_FAULT: begin
                done      = 1'b1;
                align_err = 1'b1;
            end
            default:  ;
        endcase
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R3
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rvalid |=> !mem_req && done); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> done && !mem_req); // R4
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(jump_target) && $stable(mem_addr)); // R8
endmodule

// File: rtl/script_addr_gen.sv
module script_addr_gen
    import sag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [KIND_W-1:0]     op_kind,
    input  logic                  rel_mode,
    input  logic                  tbl_mode,
    input  logic [ADDR_W-1:0]     jump_field,
    input  logic [DISP_W-1:0]     count_field,
    input  logic [ADDR_W-1:0]     script_ptr,
    input  logic [ADDR_W-1:0]     base_addr,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_rvalid,
    input  logic [ADDR_W-1:0]     mem_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  align_err,
    output logic [ADDR_W-1:0]     jump_target,
    output logic [FIELD_W-1:0]    xfer_timing,
    output logic [FIELD_W-1:0]    xfer_id,
    output logic [FIELD_W-1:0]    xfer_offset,
    output logic [FIELD_W-1:0]    xfer_period
);
    localparam int SET_W = FIELD_W * N_FIELDS;

    logic [ADDR_W-1:0] eff_target;
    logic [ADDR_W-1:0] tbl_addr;
    logic              misaligned;
    logic              load_en;
    logic [SET_W-1:0]  settings;

    sag_addr_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .KIND_W (KIND_W),
        .ALIGN_B(ALIGN_B),
        .REL_LIM(REL_KIND_LIMIT)
    ) u_calc (
        .op_kind    (op_kind),
        .rel_mode   (rel_mode),
        .jump_field (jump_field),
        .count_field(count_field),
        .script_ptr (script_ptr),
        .base_addr  (base_addr),
        .eff_target (eff_target),
        .tbl_addr   (tbl_addr),
        .misaligned (misaligned)
    );

    sag_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tbl_mode   (tbl_mode),
        .eff_target (eff_target),
        .tbl_addr   (tbl_addr),
        .misaligned (misaligned),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (done),
        .align_err  (align_err),
        .jump_target(jump_target),
        .load_en    (load_en)
    );

    sag_unpack #(
        .FIELD_W (FIELD_W),
        .N_FIELDS(N_FIELDS)
    ) u_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .word  (mem_rdata[SET_W-1:0]),
        .fields(settings)
    );

    // Field order within the word: timing high byte down to period low byte (R5)
    assign xfer_timing = settings[4*FIELD_W-1 : 3*FIELD_W];
    assign xfer_id     = settings[3*FIELD_W-1 : 2*FIELD_W];
    assign xfer_offset = settings[2*FIELD_W-1 : FIELD_W];
    assign xfer_period = settings[FIELD_W-1 : 0];

    AST_SETTINGS_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_rvalid) |=> $stable(settings)); // R6
endmodule

// File: tb/script_addr_gen_tb.sv
module script_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_kind = '0;
    logic        rel_mode = 1'b0;
    logic        tbl_mode = 1'b0;
    logic [31:0] jump_field = '0;
    logic [23:0] count_field = '0;
    logic [31:0] script_ptr = '0;
    logic [31:0] base_addr = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, busy, done, align_err;
    logic [31:0] mem_addr, jump_target;
    logic [7:0]  xfer_timing, xfer_id, xfer_offset, xfer_period;

    int checks = 0;
    int errors = 0;
    logic [31:0] cur_set = '0;

    always #2 clk = ~clk;

    script_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .rel_mode(rel_mode), .tbl_mode(tbl_mode), .jump_field(jump_field),
        .count_field(count_field), .script_ptr(script_ptr), .base_addr(base_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .align_err(align_err),
        .jump_target(jump_target), .xfer_timing(xfer_timing), .xfer_id(xfer_id),
        .xfer_offset(xfer_offset), .xfer_period(xfer_period)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [23:0] v);
        return {{8{v[23]}}, v};
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] set_now();
        return {xfer_timing, xfer_id, xfer_offset, xfer_period};
    endfunction

    task automatic run_op(input logic [2:0] kind, input bit rel, input bit tbl,
                          input logic [31:0] jf, input logic [23:0] cf,
                          input logic [31:0] ptr, input logic [31:0] base,
                          input int lat);
        logic [31:0] exp_tgt, exp_addr, w;
        bit mis, rel_ok;
        rel_ok   = rel && (kind < 3'd4);
        exp_tgt  = rel_ok ? ptr + sx(jf[23:0]) : jf;
        exp_addr = base + sx(cf);
        mis      = (base[1:0] != 2'b00);
        @(negedge clk);
        op_kind = kind; rel_mode = rel; tbl_mode = tbl; jump_field = jf;
        count_field = cf; script_ptr = ptr; base_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (tbl && !mis) begin
            chk(mem_req === 1'b1, "R3 req", {31'd0, mem_req}, 32'd1);
            chk(mem_addr === exp_addr, "R3 addr", mem_addr, exp_addr);
            chk(done === 1'b0, "R7 early done", {31'd0, done}, 32'd0);
            for (int i = 0; i < lat; i++) begin
                // R8: restart while busy with different operands
                start = 1'b1; jump_field = ~jf; base_addr = base + 32'h40;
                count_field = ~cf; script_ptr = ~ptr;
                @(negedge clk);
                start = 1'b0;
                chk(mem_req === 1'b1, "R3 req held", {31'd0, mem_req}, 32'd1);
                chk(mem_addr === exp_addr, "R8 addr kept", mem_addr, exp_addr);
                chk(set_now() === cur_set, "R6 no load while waiting", set_now(), cur_set);
            end
            w = rd_word(exp_addr);
            mem_rvalid = 1'b1; mem_rdata = w;
            @(negedge clk);
            mem_rvalid = 1'b0;
            cur_set = w;
            chk(done === 1'b1, "R7 done after read", {31'd0, done}, 32'd1);
            chk(mem_req === 1'b0, "R3 req dropped", {31'd0, mem_req}, 32'd0);
            chk(xfer_timing === w[31:24], "R5 timing", {24'd0, xfer_timing}, {24'd0, w[31:24]});
            chk(xfer_id === w[23:16], "R5 id", {24'd0, xfer_id}, {24'd0, w[23:16]});
            chk(xfer_offset === w[15:8], "R5 offset", {24'd0, xfer_offset}, {24'd0, w[15:8]});
            chk(xfer_period === w[7:0], "R5 period", {24'd0, xfer_period}, {24'd0, w[7:0]});
        end else begin
            chk(done === 1'b1, "R7 done", {31'd0, done}, 32'd1);
            chk(align_err === (tbl && mis), "R4 align_err", {31'd0, align_err},
                {31'd0, tbl && mis});
            chk(mem_req === 1'b0, "R4 no read", {31'd0, mem_req}, 32'd0);
            chk(set_now() === cur_set, "R6 settings kept", set_now(), cur_set);
        end
        if (rel_ok) chk(jump_target === exp_tgt, "R1 relative target", jump_target, exp_tgt);
        else        chk(jump_target === exp_tgt, "R2 absolute target", jump_target, exp_tgt);
        @(negedge clk);
        chk(done === 1'b0, "R7 single pulse", {31'd0, done}, 32'd0);
        chk(align_err === 1'b0, "R4 err pulse", {31'd0, align_err}, 32'd0);
        mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF ^ exp_addr;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(set_now() === cur_set, "R6 stray rvalid ignored", set_now(), cur_set);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] disps [7];
        logic [31:0] ptrs [3];
        logic [31:0] bases [3];
        int n;
        disps = '{24'h000000, 24'h000001, 24'hFFFFFF, 24'h7FFFFF,
                  24'h800000, 24'h000004, 24'hFFFFFC};
        ptrs  = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h0080_0000};
        bases = '{32'h0010_0000, 32'hFFFF_FF00, 32'h0000_0040};
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({mem_req, busy, done, align_err} === 4'b0, "R9 flags", {28'd0, mem_req, busy, done, align_err}, 32'd0);
        chk(jump_target === 32'd0, "R9 target", jump_target, 32'd0);
        chk(mem_addr === 32'd0, "R9 addr", mem_addr, 32'd0);
        chk(set_now() === 32'd0, "R9 settings", set_now(), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R9 idle", {31'd0, busy}, 32'd0);
        // R1, R2: jump target sweep
        for (int k = 0; k < 8; k++)
            for (int r = 0; r < 2; r++)
                for (int d = 0; d < 7; d++)
                    for (int p = 0; p < 3; p++)
                        run_op(3'(k), r[0], 1'b0, {8'(8'hA0 + d + p), disps[d]},
                               24'h0, ptrs[p], 32'h0, 0);
        // R3, R4, R5, R8: table sweep
        n = 0;
        for (int lo = 0; lo < 4; lo++)
            for (int b = 0; b < 3; b++)
                for (int d = 0; d < 7; d++) begin
                    run_op(3'(n % 8), 1'b1, 1'b1, {8'h3C, disps[(d + 2) % 7]}, disps[d],
                           ptrs[b], bases[b] + 32'(lo), n % 3);
                    n++;
                end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule